// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes a fixed set of interrupt input pins to a message output. Each pin has a 64-bit redirection entry. The entry holds the vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. When a pin rises and its entry is unmasked, the block sends a one-cycle message built from that entry. Choosing which processors receive the message is left to logic downstream.

Software reaches every register through two 32-bit bus locations:

- **Offset 0** is a select word.
- **Offset 16** is a data window onto the register the select word names.

The registers behind the window are:

- an ID register;
- a read-only version register;
- an arbitration-ID register;
- the redirection table, with each entry split over two consecutive select indices.

When several pins rise together, they are sent one per cycle in ascending pin order. Pins not yet sent are held as pending bits.

Top module: `irq_redirect`

## Requirements
- R1: The bus has two legal offsets. At offset 0 the select index is read and written as 8 bits; it reads back zero-extended to 32 bits. At offset 16 the window reads and writes the register the select index names. Any other offset with `bus_en` high raises `bus_err` in the same cycle, reads as zero and changes no state.
- R2: After reset the following hold:
  - The select index, ID and arbitration ID are zero.
  - Every table entry reads 0x00010000 in its low half and 0 in its high half, so only the mask is set.
  - Every pin's remembered level is low.
- R3: Select index 0x00 is the ID register. A write keeps data bits 31:24. A read returns the ID in bits 31:24 and zeros elsewhere.
- R4: Select index 0x01 reads as (entries minus 1) in bits 23:16 and 0x11 in bits 7:0, which is 0x00170011 for 24 entries. Writes to it have no effect.
- R5: Select index 0x02 is the arbitration-ID register, with the same bit 31:24 placement as the ID register.
- R6: Entry i is reached at select index 0x10+2i for bits 31:0 and at 0x11+2i for bits 63:32. Writes keep only the defined bits, and all reserved bits read as zero:
  - low half: mask 0x0001AFFF;
  - high half: mask 0xFF000000.
- R7: Select indices 0x03 to 0x0F, and those at or above 0x10+2·entries, read as zero and ignore writes.
- R8: A pin sampled high at a clock edge, after being sampled low at the previous edge, is a rising edge. An unmasked rising edge produces `msg_valid` for the one cycle after that edge. A pin held high produces no further message, and lowering a pin produces none.
- R9: A rising edge whose entry has the mask bit (bit 16) set at that edge is dropped and produces no message.
- R10: A message carries the following, taken from the entry at the edge where the message is issued:
  - the pin number;
  - vector (bits 7:0);
  - delivery mode (10:8);
  - destination mode (11);
  - polarity (13);
  - trigger (15);
  - destination (63:56).
- R11: At most one message is issued per cycle. Among rising and pending pins, the lowest-numbered pin is sent first. The others are kept pending and sent on later cycles in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Illegal offset flag |
| irq_pin | input | NPINS | Interrupt input pins |
| msg_valid | output | 1 | Message strobe, one cycle per message |
| msg_src | output | 5 | Pin that caused the message |
| msg_dest | output | 8 | Destination field |
| msg_vector | output | 8 | Vector field |
| msg_dmode | output | 3 | Delivery mode |
| msg_destmode | output | 1 | Destination mode |
| msg_polarity | output | 1 | Polarity |
| msg_trigger | output | 1 | Trigger mode |

## Verification
The bench goes after several corner cases, each tied to a specific design fault:

- **Table halves.** Writing all ones to the first and last table halves catches a wrong reserved mask or an off-by-one in the index decode. Such a design would leak status bits or reach an entry one past the table.
- **Bus corners.** Writes to the version register, to undefined indices and to illegal offsets must leave every register untouched. A decoder that aliases these would overwrite the ID or the select word.
- **Edge detection.** A pin held high, a pin lowered and raised again, and a pin unmasked while already high catch level-triggered or stale-state edge detection.
- **Simultaneous rises.** Three pins rising in one cycle must come out as three consecutive messages in ascending order. A wrong arbiter would lose a pin, repeat one, or reorder them.

// File: rtl/irq_redirect.sv
module irq_redirect #(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int PW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_err,
  input  logic [NPINS-1:0] irq_pin,
  output logic             msg_valid,
  output logic [PW-1:0]    msg_src,
  output logic [7:0]       msg_dest,
  output logic [7:0]       msg_vector,
  output logic [2:0]       msg_dmode,
  output logic             msg_destmode,
  output logic             msg_polarity,
  output logic             msg_trigger
);
  localparam int TBL_END = 16 + 2 * NPINS;
  localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

  logic [7:0]       sel_q, id_q, arb_q;
  logic [63:0]      tab_q [NPINS];
  logic [NPINS-1:0] pin_q, pend_q, mask_v, cand, grant;
  logic [PW-1:0]    gidx;
  logic [63:0]      msg_ent_q;
  logic [31:0]      win_rd;

  wire       at_sel = bus_addr == 5'd0;
  wire       at_win = bus_addr == 5'd16;
  wire       in_tbl = ({24'd0, sel_q} >= 32'd16) && ({24'd0, sel_q} < TBL_END);
  wire [7:0] toff   = sel_q - 8'd16;
  wire [PW-1:0] tidx = toff[PW:1];
  wire       wr_win = bus_en && bus_wr && at_win;

  assign bus_err = bus_en && !at_sel && !at_win;

  always_comb begin
    case (sel_q)
      8'h00:   win_rd = {id_q, 24'd0};
      8'h01:   win_rd = {8'd0, 8'(NPINS - 1), 8'd0, VERSION};
      8'h02:   win_rd = {arb_q, 24'd0};
      default: win_rd = !in_tbl ? 32'd0 :
                        sel_q[0] ? tab_q[tidx][63:32] : tab_q[tidx][31:0];
    endcase
  end

  assign bus_rdata = (bus_en && !bus_wr) ?
                     (at_sel ? {24'd0, sel_q} : at_win ? win_rd : 32'd0) : 32'd0;

  for (genvar i = 0; i < NPINS; i++) begin : g_mask
    assign mask_v[i] = tab_q[i][16];
  end

  assign cand  = pend_q | (irq_pin & ~pin_q & ~mask_v);
  assign grant = cand & (~cand + 1'b1);

  always_comb begin
    gidx = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (cand[i]) gidx = PW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      arb_q     <= '0;
      pin_q     <= '0;
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_src   <= '0;
      msg_ent_q <= '0;
      for (int i = 0; i < NPINS; i++) tab_q[i] <= ENT_RST;
    end else begin
      pin_q     <= irq_pin;
      pend_q    <= cand & ~grant;
      msg_valid <= |cand;
      msg_src   <= gidx;
      msg_ent_q <= tab_q[gidx];
      if (bus_en && bus_wr && at_sel) sel_q <= bus_wdata[7:0];
      if (wr_win) begin
        if (sel_q == 8'h00) id_q  <= bus_wdata[31:24];
        if (sel_q == 8'h02) arb_q <= bus_wdata[31:24];
        if (in_tbl) begin
          if (sel_q[0]) tab_q[tidx][63:32] <= bus_wdata & HI_KEEP;
          else          tab_q[tidx][31:0]  <= bus_wdata & LO_KEEP;
        end
      end
    end
  end

  assign msg_vector   = msg_ent_q[7:0];
  assign msg_dmode    = msg_ent_q[10:8];
  assign msg_destmode = msg_ent_q[11];
  assign msg_polarity = msg_ent_q[13];
  assign msg_trigger  = msg_ent_q[15];
  assign msg_dest     = msg_ent_q[63:56];
endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
  parameter int NPINS = 24,
  localparam int PW = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic [NPINS-1:0] irq_pin,
  input logic [NPINS-1:0] pin_q,
  input logic [NPINS-1:0] pend_q,
  input logic             msg_valid,
  input logic [PW-1:0]    msg_src
);
  assert_illegal_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr != 5'd0 && bus_addr != 5'd16) |-> (bus_err && bus_rdata == 32'd0));

  assert_no_err_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> !bus_err);

  assert_sel_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && bus_addr == 5'd0) |-> bus_rdata[31:8] == 24'd0);

  assert_src_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> int'(msg_src) < NPINS);

  assert_no_spurious_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0 && (irq_pin & ~pin_q) == '0) |=> !msg_valid);
endmodule

bind irq_redirect irq_redirect_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .irq_pin(irq_pin), .pin_q(pin_q), .pend_q(pend_q),
  .msg_valid(msg_valid), .msg_src(msg_src)
);

// File: tb/irq_redirect_test.sv
module irq_redirect_test;
  localparam int NP = 24;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [NP-1:0] irq_pin = '0;
  logic msg_valid, msg_destmode, msg_polarity, msg_trigger;
  logic [PW-1:0] msg_src;
  logic [7:0] msg_dest, msg_vector;
  logic [2:0] msg_dmode;

  int n_tests = 0, n_fail = 0, n_msg = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_redirect uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_pin(irq_pin), .msg_valid(msg_valid),
    .msg_src(msg_src), .msg_dest(msg_dest), .msg_vector(msg_vector),
    .msg_dmode(msg_dmode), .msg_destmode(msg_destmode),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [63:0] mtab [NP];
  logic [7:0]  msel;
  logic [NP-1:0] mpinq, mpend;
  bit          e_valid;
  int          e_src;
  logic [63:0] e_ent;

  always @(posedge clk) begin
    if (!rst_n) begin
      msel = 0; mpinq = 0; mpend = 0; e_valid = 0; e_src = 0; e_ent = 0;
      for (int i = 0; i < NP; i++) mtab[i] = 64'h1_0000;
    end else begin
      logic [NP-1:0] c;
      c = mpend;
      for (int i = 0; i < NP; i++)
        if (irq_pin[i] && !mpinq[i] && !mtab[i][16]) c[i] = 1'b1;
      e_valid = 0;
      for (int i = 0; i < NP; i++)
        if (c[i] && !e_valid) begin
          e_valid = 1; e_src = i; e_ent = mtab[i]; c[i] = 1'b0;
        end
      mpend = c;
      mpinq = irq_pin;
      if (bus_en && bus_wr && bus_addr == 0) msel = bus_wdata[7:0];
      else if (bus_en && bus_wr && bus_addr == 16 && msel >= 16 && msel < 16 + 2*NP) begin
        if (msel[0]) mtab[(msel-16)/2][63:32] = bus_wdata & 32'hFF00_0000;
        else         mtab[(msel-16)/2][31:0]  = bus_wdata & 32'h0001_AFFF;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 R9 R11 msg_valid", msg_valid, e_valid);
      if (msg_valid) n_msg++;
      if (e_valid && msg_valid) begin
        chk("R11 msg_src order", msg_src, e_src);
        chk("R10 dest", msg_dest, e_ent[63:56]);
        chk("R10 vector", msg_vector, e_ent[7:0]);
        chk("R10 fields", {msg_dmode, msg_destmode, msg_polarity, msg_trigger},
            {e_ent[10:8], e_ent[11], e_ent[13], e_ent[15]});
      end
    end
  end

  task automatic acc(input logic wr, input logic [4:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    bus_en = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    if (!wr) chk(tag, bus_rdata, exp);
    chk({tag, " err"}, bus_err, exp_err);
    @(posedge clk); #1;
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic wsel(input logic [7:0] s);
    acc(1, 0, {24'd0, s}, 0, 0, "R1 sel write");
  endtask

  task automatic rdw(input logic [7:0] s, input logic [31:0] exp, input string tag);
    wsel(s);
    acc(0, 16, 0, exp, 0, tag);
  endtask

  task automatic wrw(input logic [7:0] s, input logic [31:0] d);
    wsel(s);
    acc(1, 16, d, 0, 0, "window write");
  endtask

  task automatic pins(input logic [NP-1:0] v, input int hold);
    @(negedge clk); irq_pin = v;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    acc(0, 0, 0, 32'h0, 0, "R2 sel reset");
    rdw(8'h00, 32'h0, "R2 id reset");
    rdw(8'h02, 32'h0, "R2 arb reset");
    rdw(8'h10, 32'h0001_0000, "R2 entry0 low reset");
    rdw(8'h3F, 32'h0, "R2 entry23 high reset");
    // R3, R4, R5
    wrw(8'h00, 32'hA512_3456); rdw(8'h00, 32'hA500_0000, "R3 id");
    rdw(8'h01, 32'h0017_0011, "R4 version");
    wrw(8'h01, 32'hFFFF_FFFF); rdw(8'h01, 32'h0017_0011, "R4 write ignored");
    wrw(8'h02, 32'h3C00_FFFF); rdw(8'h02, 32'h3C00_0000, "R5 arb");
    rdw(8'h00, 32'hA500_0000, "R5 id untouched");
    // R6 table masks and mapping
    wrw(8'h10, 32'hFFFF_FFFF); rdw(8'h10, 32'h0001_AFFF, "R6 low mask");
    wrw(8'h11, 32'hFFFF_FFFF); rdw(8'h11, 32'hFF00_0000, "R6 high mask");
    wrw(8'h3F, 32'h1234_5678); rdw(8'h3F, 32'h1200_0000, "R6 last high");
    rdw(8'h3E, 32'h0001_0000, "R6 last low untouched");
    // R7 undefined indices
    wrw(8'h03, 32'hFFFF_FFFF); rdw(8'h03, 32'h0, "R7 idx 0x03");
    wrw(8'h0F, 32'hFFFF_FFFF); rdw(8'h0F, 32'h0, "R7 idx 0x0F");
    wrw(8'h40, 32'hFFFF_FFFF); rdw(8'h40, 32'h0, "R7 idx 0x40");
    rdw(8'h00, 32'hA500_0000, "R7 id untouched");
    // R1 illegal offsets
    wsel(8'h02);
    acc(1, 8, 32'h0000_00FF, 0, 1, "R1 illegal write");
    acc(0, 4, 0, 32'h0, 1, "R1 illegal read");
    acc(0, 0, 0, 32'h02, 0, "R1 sel kept");
    // Program entries: unmasked 0,3,5,23; masked 7
    foreach (mtab[i]) begin
      if (i == 0 || i == 3 || i == 5 || i == 23) begin
        wrw(8'(16 + 2*i), 32'h0000_8A40 + i + (i << 8));
        wrw(8'(17 + 2*i), {8'(8'h80 + i), 24'd0});
      end
    end
    wrw(8'h1E, 32'h0001_2147);
    // R8 single rise, hold, lower, re-raise
    pins(24'h000001, 6);
    pins(24'h000000, 3);
    pins(24'h000001, 4);
    pins(24'h000000, 2);
    // R9 masked pin, then unmask while high: no edge
    pins(24'h000080, 4);
    wrw(8'h1E, 32'h0000_2147);
    repeat (3) @(negedge clk);
    pins(24'h000000, 2);
    // R11 simultaneous rises
    pins(24'h800028, 8);
    pins(24'h000000, 3);
    chk("R8 R9 R11 total messages", n_msg, 5);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule